// File: doc/BRIEF.md
# Interrupt Source Gating Unit

This unit gathers thirteen single-cycle event pulses from a serial channel's receive, transmit and modem logic and raises one interrupt line to the processor. Each event sets its own sticky pending bit, whether or not the source is enabled. Software clears a pending bit by writing a one to it. A separate gate (mask) bit per source decides whether that pending bit can reach the interrupt line.

The gate is never written as a whole word. One write port turns sources on, and a second write port turns them off. Each port acts only on the bit positions written as one. Software can therefore enable or disable a single source without a read-modify-write sequence that could race with other code. The gate and pending vectors are both visible as outputs.

The interrupt line is registered. It follows the pending and gate state with one cycle of delay. Every write port is a plain strobe with a data word. The unit never stalls a write, so the ports carry no ready signal and apply no back-pressure.

Top module: `irq_gate_unit`

## Requirements
- R1: While `rst_n` is low, at the following clock edge the gate vector, the pending vector and `irq_o` all become zero.
- R2: A one on `event_i[k]` at a clock edge sets `pending_o[k]` after that edge. The bit stays set after the pulse ends. This happens whether or not gate bit k is set.
- R3: When `ack_we_i` is high, each bit written as one in `ack_bits_i` clears the matching pending bit at that edge. Bits written as zero keep their value.
- R4: If an event and an acknowledge hit the same pending bit in the same cycle, the bit ends up set.
- R5: When `on_we_i` is high, each bit written as one in `on_bits_i` sets the matching gate bit. Other gate bits keep their value.
- R6: When `off_we_i` is high, each bit written as one in `off_bits_i` clears the matching gate bit. Other gate bits keep their value.
- R7: If the on port and the off port both write a one to the same bit in the same cycle, that gate bit ends up cleared.
- R8: `irq_o` in a cycle equals the OR over all k of (`pending_o[k]` AND `gate_o[k]`), taken from the previous cycle.
- R9: Bit positions are fixed: 0 receive level reached, 1 receive queue empty, 2 receive queue full, 3 transmit queue empty, 4 transmit queue full, 5 receive overrun, 6 framing error, 7 parity error, 8 receive idle timeout, 9 modem line change, 10 transmit level reached, 11 transmit queue nearly full, 12 transmit overrun. Event input k drives only pending bit k.
- R10: When a write strobe is low, its data word is ignored. The gate or pending vector it would have touched does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| event_i | input | 13 | Raw event pulses, one per source |
| on_we_i | input | 1 | Strobe for the gate-set port |
| on_bits_i | input | 13 | Gate bits to set |
| off_we_i | input | 1 | Strobe for the gate-clear port |
| off_bits_i | input | 13 | Gate bits to clear |
| ack_we_i | input | 1 | Strobe for the pending-clear port |
| ack_bits_i | input | 13 | Pending bits to clear |
| gate_o | output | 13 | Current gate (enable) vector |
| pending_o | output | 13 | Current sticky pending vector |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The main sequence runs single-bit and multi-bit patterns through each port. It also drives patterns where the same bit is hit from two sides at once, so that a design which lets the wrong side win is caught. Data words are presented with their strobe low to show that the strobe alone gates each write. A walk over all thirteen event inputs separates a correct bit mapping from a shifted or swapped one. The interrupt line is checked against the pending and gate state of the previous cycle, so a version that drops the output register, or that ignores the gate, shows a different value.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int unsigned IRQ_SRC_COUNT = 13;

  // Bit position of each event source; a software driver decodes these.
  typedef enum int unsigned {
    SRC_RX_LEVEL     = 0,
    SRC_RX_EMPTY     = 1,
    SRC_RX_FULL      = 2,
    SRC_TX_EMPTY     = 3,
    SRC_TX_FULL      = 4,
    SRC_RX_OVERRUN   = 5,
    SRC_FRAME_ERR    = 6,
    SRC_PARITY_ERR   = 7,
    SRC_RX_IDLE      = 8,
    SRC_MODEM_CHANGE = 9,
    SRC_TX_LEVEL     = 10,
    SRC_TX_NEAR_FULL = 11,
    SRC_TX_OVERRUN   = 12
  } irq_src_e;
endpackage

// File: rtl/irq_pend_cell.sv
// One sticky pending bit: a set request takes priority over a clear request.
module irq_pend_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/irq_gate_bank.sv
// Gate vector driven by separate set and clear ports; clear takes priority.
module irq_gate_bank #(
  parameter int unsigned N = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         on_we_i,
  input  logic [N-1:0] on_bits_i,
  input  logic         off_we_i,
  input  logic [N-1:0] off_bits_i,
  output logic [N-1:0] gate_q
);
  logic [N-1:0] set_eff, clr_eff;

  assign set_eff = on_we_i  ? on_bits_i  : '0;
  assign clr_eff = off_we_i ? off_bits_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= '0;
    else        gate_q <= (gate_q | set_eff) & ~clr_eff;
  end
endmodule

// File: rtl/irq_out_stage.sv
// Registered reduction of pending-and-gated sources to one request line.
module irq_out_stage #(
  parameter int unsigned N = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pending_i,
  input  logic [N-1:0] gate_i,
  output logic         irq_q
);
  logic [N-1:0] live;

  assign live = pending_i & gate_i;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |live;
  end
endmodule

// File: rtl/irq_gate_unit.sv
module irq_gate_unit #(
  parameter int unsigned NUM_SRC = irq_gate_pkg::IRQ_SRC_COUNT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] event_i,
  input  logic               on_we_i,
  input  logic [NUM_SRC-1:0] on_bits_i,
  input  logic               off_we_i,
  input  logic [NUM_SRC-1:0] off_bits_i,
  input  logic               ack_we_i,
  input  logic [NUM_SRC-1:0] ack_bits_i,
  output logic [NUM_SRC-1:0] gate_o,
  output logic [NUM_SRC-1:0] pending_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] ack_eff;

  assign ack_eff = ack_we_i ? ack_bits_i : '0;

  // R2 R3 R4 R9: one sticky cell per source, event input k feeds cell k
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_pend
    irq_pend_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (event_i[k]),
      .clr_i (ack_eff[k]),
      .q_o   (pending_o[k])
    );
  end

  // R5 R6 R7
  irq_gate_bank #(.N(NUM_SRC)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .on_we_i    (on_we_i),
    .on_bits_i  (on_bits_i),
    .off_we_i   (off_we_i),
    .off_bits_i (off_bits_i),
    .gate_q     (gate_o)
  );

  // R8
  irq_out_stage #(.N(NUM_SRC)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .pending_i (pending_o),
    .gate_i    (gate_o),
    .irq_q     (irq_o)
  );
endmodule

// File: rtl/irq_gate_checker.sv
module irq_gate_checker #(
  parameter int unsigned NUM_SRC = 13
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] event_i,
  input logic               on_we_i,
  input logic [NUM_SRC-1:0] on_bits_i,
  input logic               off_we_i,
  input logic [NUM_SRC-1:0] off_bits_i,
  input logic               ack_we_i,
  input logic [NUM_SRC-1:0] ack_bits_i,
  input logic [NUM_SRC-1:0] gate_o,
  input logic [NUM_SRC-1:0] pending_o,
  input logic               irq_o
);
  a_r2_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (event_i != '0) |=> ((pending_o & $past(event_i)) == $past(event_i)));

  a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we_i |=> ((pending_o & $past(ack_bits_i & ~event_i)) == '0));

  a_r5_on_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (on_we_i && !off_we_i) |=> ((gate_o & $past(on_bits_i)) == $past(on_bits_i)));

  a_r7_off_wins: assert property (@(posedge clk) disable iff (!rst_n)
    off_we_i |=> ((gate_o & $past(off_bits_i)) == '0));

  a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == |($past(pending_o & gate_o))));

  a_r10_gate_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!on_we_i && !off_we_i) |=> $stable(gate_o));

  a_r10_pend_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_we_i && event_i == '0) |=> $stable(pending_o));
endmodule

bind irq_gate_unit irq_gate_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .event_i    (event_i),
  .on_we_i    (on_we_i),
  .on_bits_i  (on_bits_i),
  .off_we_i   (off_we_i),
  .off_bits_i (off_bits_i),
  .ack_we_i   (ack_we_i),
  .ack_bits_i (ack_bits_i),
  .gate_o     (gate_o),
  .pending_o  (pending_o),
  .irq_o      (irq_o)
);

// File: tb/test_irq_gate_unit.sv
module test_irq_gate_unit;
  localparam int N = 13;

  typedef struct packed {
    logic [7:0]   req;
    logic         on_we;
    logic [N-1:0] on_bits;
    logic         off_we;
    logic [N-1:0] off_bits;
    logic         ack_we;
    logic [N-1:0] ack_bits;
    logic [N-1:0] evt;
    logic [N-1:0] exp_gate;
    logic [N-1:0] exp_pend;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{8'd2,  1'b0, 13'h0000, 1'b0, 13'h0000, 1'b0, 13'h0000, 13'h0001, 13'h0000, 13'h0001}, // R2 masked latch
    '{8'd5,  1'b1, 13'h0001, 1'b0, 13'h0000, 1'b0, 13'h0000, 13'h0000, 13'h0001, 13'h0001}, // R5
    '{8'd8,  1'b0, 13'h0000, 1'b0, 13'h0000, 1'b0, 13'h0000, 13'h0000, 13'h0001, 13'h0001}, // R8 irq high
    '{8'd3,  1'b0, 13'h0000, 1'b0, 13'h0000, 1'b1, 13'h0000, 13'h0000, 13'h0001, 13'h0001}, // R3 zero ack
    '{8'd3,  1'b0, 13'h0000, 1'b0, 13'h0000, 1'b1, 13'h0001, 13'h0000, 13'h0001, 13'h0000}, // R3 ack clears
    '{8'd4,  1'b0, 13'h0000, 1'b0, 13'h0000, 1'b1, 13'h1000, 13'h1000, 13'h0001, 13'h1000}, // R4 event wins
    '{8'd10, 1'b0, 13'h1FFF, 1'b0, 13'h0000, 1'b0, 13'h0000, 13'h0000, 13'h0001, 13'h1000}, // R10 on strobe low
    '{8'd7,  1'b1, 13'h1000, 1'b1, 13'h1000, 1'b0, 13'h0000, 13'h0000, 13'h0001, 13'h1000}, // R7 off wins
    '{8'd5,  1'b1, 13'h1F00, 1'b0, 13'h0000, 1'b0, 13'h0000, 13'h0000, 13'h1F01, 13'h1000}, // R5 multi
    '{8'd6,  1'b0, 13'h0000, 1'b1, 13'h0F00, 1'b0, 13'h0000, 13'h0000, 13'h1001, 13'h1000}, // R6 partial
    '{8'd6,  1'b0, 13'h0000, 1'b1, 13'h1000, 1'b0, 13'h0000, 13'h0000, 13'h0001, 13'h1000}, // R6
    '{8'd8,  1'b0, 13'h0000, 1'b0, 13'h0000, 1'b0, 13'h0000, 13'h0000, 13'h0001, 13'h1000}, // R8 gated off
    '{8'd2,  1'b0, 13'h0000, 1'b0, 13'h0000, 1'b0, 13'h0000, 13'h00A5, 13'h0001, 13'h10A5}, // R2 multi
    '{8'd10, 1'b0, 13'h0000, 1'b0, 13'h0000, 1'b0, 13'h1FFF, 13'h0000, 13'h0001, 13'h10A5}, // R10 ack strobe low
    '{8'd4,  1'b0, 13'h0000, 1'b0, 13'h0000, 1'b1, 13'h1FFF, 13'h0040, 13'h0001, 13'h0040}, // R4 under full ack
    '{8'd6,  1'b0, 13'h0000, 1'b1, 13'h1FFF, 1'b0, 13'h0000, 13'h0000, 13'h0000, 13'h0040}, // R6 all off
    '{8'd8,  1'b0, 13'h0000, 1'b0, 13'h0000, 1'b0, 13'h0000, 13'h0000, 13'h0000, 13'h0040}  // R8
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] event_i, on_bits_i, off_bits_i, ack_bits_i;
  logic         on_we_i, off_we_i, ack_we_i;
  logic [N-1:0] gate_o, pending_o;
  logic         irq_o;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  irq_gate_unit #(.NUM_SRC(N)) i_irq_gate_unit (
    .clk(clk), .rst_n(rst_n), .event_i(event_i),
    .on_we_i(on_we_i), .on_bits_i(on_bits_i),
    .off_we_i(off_we_i), .off_bits_i(off_bits_i),
    .ack_we_i(ack_we_i), .ack_bits_i(ack_bits_i),
    .gate_o(gate_o), .pending_o(pending_o), .irq_o(irq_o)
  );

  task automatic idle_inputs();
    event_i = '0; on_we_i = 1'b0; on_bits_i = '0;
    off_we_i = 1'b0; off_bits_i = '0; ack_we_i = 1'b0; ack_bits_i = '0;
  endtask

  task automatic check(input string req, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [N-1:0] prev_gate, prev_pend;
    idle_inputs();
    // R1: reset state, inputs active during reset are ignored
    rst_n = 1'b0;
    event_i = '1; on_we_i = 1'b1; on_bits_i = '1;
    repeat (2) @(negedge clk);
    check("R1", "gate", gate_o, '0);
    check("R1", "pending", pending_o, '0);
    check("R1", "irq", {12'd0, irq_o}, '0);
    idle_inputs();
    rst_n = 1'b1;
    @(negedge clk);

    prev_gate = '0; prev_pend = '0;
    foreach (VECS[i]) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      on_we_i  = VECS[i].on_we;  on_bits_i  = VECS[i].on_bits;
      off_we_i = VECS[i].off_we; off_bits_i = VECS[i].off_bits;
      ack_we_i = VECS[i].ack_we; ack_bits_i = VECS[i].ack_bits;
      event_i  = VECS[i].evt;
      @(negedge clk);
      check(tag, "gate", gate_o, VECS[i].exp_gate);
      check(tag, "pending", pending_o, VECS[i].exp_pend);
      // R8: irq reflects the state held during the previous cycle
      check("R8", "irq", {12'd0, irq_o}, {12'd0, |(prev_gate & prev_pend)});
      prev_gate = VECS[i].exp_gate;
      prev_pend = VECS[i].exp_pend;
    end
    idle_inputs();

    // R9: walk every event input, each must land on its own pending bit
    ack_we_i = 1'b1; ack_bits_i = '1;
    @(negedge clk);
    ack_we_i = 1'b0;
    for (int k = 0; k < N; k++) begin
      event_i = N'(1) << k;
      @(negedge clk);
      event_i = '0;
      check("R9", $sformatf("bit %0d", k), pending_o, N'(1) << k);
      ack_we_i = 1'b1; ack_bits_i = N'(1) << k;
      @(negedge clk);
      ack_we_i = 1'b0;
    end
    check("R9", "transmit overrun id", 13'(irq_gate_pkg::SRC_TX_OVERRUN), 13'd12);

    // R1: reset in the middle of activity clears everything
    on_we_i = 1'b1; on_bits_i = '1; event_i = '1;
    @(negedge clk);
    idle_inputs();
    @(negedge clk);
    check("R8", "irq before reset", {12'd0, irq_o}, 13'd1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "gate after reset", gate_o, '0);
    check("R1", "pending after reset", pending_o, '0);
    check("R1", "irq after reset", {12'd0, irq_o}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule